// File: doc/BRIEF.md
# DMA Channel Loop-Control Sequencer

This block sequences one channel of a descriptor-driven DMA engine. A start, either from the `hw_start` input or from a self-clearing bit in the control register, marks the channel busy and clears its completion flag. The block then runs a minor loop of read/write beat pairs over a request/grant bus handshake. After every granted access it can pause for a fixed number of cycles to throttle its share of the bus. Each finished minor loop consumes one unit of the current major iteration count.

When the current count is used up, the block reloads it from the beginning count and raises the completion flag. Depending on two enable bits, it then signals a start to a linked channel, asks for a 32-byte descriptor reload from an aligned pointer, or does both in a fixed order. An error input stops the channel at once. Address generation, the data path and the descriptor fetch itself belong to other blocks.

Software sets up the channel through a small write port. The address selects the field:

| Address | Field and bit positions |
|---|---|
| 0 | current count, in `wr_data[CNT_W-1:0]` |
| 1 | beginning count, in `wr_data[CNT_W-1:0]` |
| 2 | control register: `[1:0]` throttle code, `[2]` link enable, `[3]` reload enable, `[9:4]` link channel, `[10]` software start |
| 3 | beats per minor loop, in `wr_data[BEAT_W-1:0]`; a value of 0 acts as 1 |
| 4 | reload pointer; bits `[4:0]` are discarded |

Top module: `dma_loop_seq`

## Requirements
- R1: Each completed minor loop lowers `citer` by one. When a minor loop completes with `citer` at 1 (or 0), `citer` is reloaded from the beginning count written at address 1. A channel set up with both counts at 1 serves exactly one request per major loop.
- R2: The throttle code in control bits [1:0] sets an idle gap after every granted access, including the last one of the loop. Code 00 and code 01 give no gap, 10 gives 4 cycles and 11 gives 8 cycles. With the grant always high, `active` stays high for 2·beats·(1+gap) cycles.
- R3: A minor loop consists of `beats` pairs of accesses. Each pair is a read (`bus_wr`=0) followed by a write (`bus_wr`=1). `bus_req` is raised only while the channel is active. It stays high, with `bus_wr` unchanged, until `bus_gnt` is seen.
- R4: `done` rises on the same clock edge on which the minor loop that exhausts the major count ends. It is cleared on the edge on which the channel is launched, before any access is granted. `done` and `active` are never high together.
- R5: `active` rises on the edge after a start request is seen while the channel is idle. It falls when the minor loop ends or when an error is seen.
- R6: If link enable (control bit 2) is set when the major loop ends, `link_valid` is high for exactly one cycle, starting on the completion edge, and `link_ch` carries the 6-bit channel number from control bits [9:4]. If link enable is clear, there is no pulse.
- R7: If reload enable (control bit 3) is set when the major loop ends, `sg_req` pulses for one cycle with `sg_ptr` equal to the written pointer with bits [4:0] cleared. The pulse starts on the completion edge when linking is off, and one cycle after the link pulse when linking is on.
- R8: A control write made while `done` is high stores link enable and reload enable as 0, whatever the written values.
- R9: An error while the channel is active aborts it on the next edge. `citer` keeps its value and `done` stays low.
- R10: The software start bit (control bit 10) launches the channel once and clears itself on launch, so no second loop follows.
- R11: After reset, `active`, `done`, `bus_req`, `link_valid`, `sg_req` and `citer` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Field write strobe |
| wr_addr | input | 3 | Field select (see the address table above) |
| wr_data | input | PTR_W | Write data |
| hw_start | input | 1 | Hardware service request |
| err_in | input | 1 | Error report; aborts the channel |
| bus_gnt | input | 1 | Grant for the pending access |
| bus_req | output | 1 | Access request |
| bus_wr | output | 1 | Direction of the access: 0 read, 1 write |
| active | output | 1 | Channel is executing |
| done | output | 1 | Major loop completed |
| citer | output | CNT_W | Current major iteration count |
| link_valid | output | 1 | One-cycle start request for a linked channel |
| link_ch | output | 6 | Linked channel number |
| sg_req | output | 1 | One-cycle descriptor reload request |
| sg_ptr | output | PTR_W | 32-byte aligned descriptor pointer |

## Verification
The bench sweeps all four throttle codes against loops of one to three beats and major counts of one to three. The measured busy time separates the reserved code from the two stalling codes, and it also shows whether the gap follows the last access. Stepping through each major count shows whether the decrement and the reload happen at the right step, and whether `done`, the link pulse and the reload pulse appear only on the final step and in the right order relative to each other. Separate patterns hold the grant low, write control while `done` is high, abort with an error, and start from the software bit. These tell request holding, enable forcing, abort handling and the self-clear of the start bit apart from the normal sequence.

// File: rtl/dls_pkg.sv
package dls_pkg;
  localparam int STALL_W = 4;
  localparam int LINK_W  = 6;

  localparam logic [2:0] A_CITER = 3'd0;
  localparam logic [2:0] A_BITER = 3'd1;
  localparam logic [2:0] A_CTRL  = 3'd2;
  localparam logic [2:0] A_BEATS = 3'd3;
  localparam logic [2:0] A_SGPTR = 3'd4;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_XFER,
    SQ_HOLD
  } seq_state_e;

  // Control register image; the layout follows the write-port bit positions.
  typedef struct packed {
    logic              sw_go;
    logic [LINK_W-1:0] ch;
    logic              sg;
    logic              lk;
    logic [1:0]        bw;
  } ctrl_t;

  function automatic logic [STALL_W-1:0] stall_cycles(input logic [1:0] code);
    case (code)
      2'b10:   stall_cycles = STALL_W'(4);
      2'b11:   stall_cycles = STALL_W'(8);
      default: stall_cycles = '0;
    endcase
  endfunction
endpackage

// File: rtl/dls_throttle.sv
module dls_throttle
  import dls_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [STALL_W-1:0] len,
  output logic               hold_end
);
  logic [STALL_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= len;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign hold_end = (cnt == STALL_W'(1));
endmodule

// File: rtl/dls_major_ctr.sv
module dls_major_ctr #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_cur,
  input  logic             ld_beg,
  input  logic [CNT_W-1:0] wval,
  input  logic             step,
  output logic [CNT_W-1:0] cur,
  output logic             last
);
  logic [CNT_W-1:0] beg;

  assign last = (cur <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= '0;
      beg <= '0;
    end else begin
      if (ld_beg) beg <= wval;
      if (ld_cur) begin
        cur <= wval;
      end else if (step) begin
        cur <= last ? beg : cur - 1'b1;
      end
    end
  end
endmodule

// File: rtl/dls_link.sv
module dls_link
  import dls_pkg::*;
#(
  parameter int PTR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic              lk_en,
  input  logic              sg_en,
  input  logic [LINK_W-1:0] ch_in,
  input  logic [PTR_W-6:0]  blk_in,
  output logic              link_valid,
  output logic [LINK_W-1:0] link_ch,
  output logic              sg_req,
  output logic [PTR_W-1:0]  sg_ptr
);
  logic             sg_wait;
  logic [PTR_W-6:0] blk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      link_valid <= 1'b0;
      link_ch    <= '0;
      sg_req     <= 1'b0;
      sg_wait    <= 1'b0;
      blk_q      <= '0;
    end else begin
      link_valid <= fire & lk_en;
      if (fire & lk_en) link_ch <= ch_in;
      sg_req  <= (fire & sg_en & ~lk_en) | sg_wait;
      sg_wait <= fire & sg_en & lk_en;
      if (fire & sg_en) blk_q <= blk_in;
    end
  end

  assign sg_ptr = {blk_q, 5'b00000};
endmodule

// File: rtl/dma_loop_seq.sv
module dma_loop_seq
  import dls_pkg::*;
#(
  parameter int CNT_W  = 15,
  parameter int BEAT_W = 4,
  parameter int PTR_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [PTR_W-1:0]  wr_data,
  input  logic              hw_start,
  input  logic              err_in,
  input  logic              bus_gnt,
  output logic              bus_req,
  output logic              bus_wr,
  output logic              active,
  output logic              done,
  output logic [CNT_W-1:0]  citer,
  output logic              link_valid,
  output logic [LINK_W-1:0] link_ch,
  output logic              sg_req,
  output logic [PTR_W-1:0]  sg_ptr
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t              cfg, wc;
  logic [BEAT_W-1:0]  beats, beat_idx;
  logic [PTR_W-6:0]   sg_blk;
  seq_state_e         st;
  logic               phase, tail;
  logic               launch, granted, final_acc, finish, hold_end, major_last;
  logic [STALL_W-1:0] gap;

  assign wc = ctrl_t'(wr_data[CTRL_W-1:0]);

  always_comb begin
    gap       = stall_cycles(cfg.bw);
    launch    = (st == SQ_IDLE) && (hw_start || cfg.sw_go);
    granted   = (st == SQ_XFER) && bus_gnt && !err_in;
    final_acc = phase && (({1'b0, beat_idx} + 1'b1) >= {1'b0, beats});
    finish    = (granted && final_acc && (gap == '0)) ||
                ((st == SQ_HOLD) && !err_in && hold_end && tail);
  end

  // Configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg    <= '0;
      beats  <= '0;
      sg_blk <= '0;
    end else begin
      if (launch) cfg.sw_go <= 1'b0;
      if (wr_en) begin
        case (wr_addr)
          A_CTRL: begin
            cfg.bw <= wc.bw;
            cfg.lk <= wc.lk & ~done;
            cfg.sg <= wc.sg & ~done;
            cfg.ch <= wc.ch;
            if (wc.sw_go) cfg.sw_go <= 1'b1;
          end
          A_BEATS: beats  <= wr_data[BEAT_W-1:0];
          A_SGPTR: sg_blk <= wr_data[PTR_W-1:5];
          default: ;
        endcase
      end
    end
  end

  // Minor-loop sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SQ_IDLE;
      phase    <= 1'b0;
      beat_idx <= '0;
      tail     <= 1'b0;
      active   <= 1'b0;
      done     <= 1'b0;
    end else begin
      unique case (st)
        SQ_IDLE: begin
          if (launch) begin
            st       <= SQ_XFER;
            phase    <= 1'b0;
            beat_idx <= '0;
            tail     <= 1'b0;
            active   <= 1'b1;
            done     <= 1'b0;
          end
        end
        SQ_XFER: begin
          if (err_in) begin
            st     <= SQ_IDLE;
            active <= 1'b0;
          end else if (bus_gnt) begin
            phase <= ~phase;
            if (phase) beat_idx <= beat_idx + 1'b1;
            tail <= final_acc;
            if (gap != '0) begin
              st <= SQ_HOLD;
            end else if (final_acc) begin
              st     <= SQ_IDLE;
              active <= 1'b0;
            end
          end
        end
        SQ_HOLD: begin
          if (err_in) begin
            st     <= SQ_IDLE;
            active <= 1'b0;
          end else if (hold_end) begin
            if (tail) begin
              st     <= SQ_IDLE;
              active <= 1'b0;
            end else begin
              st <= SQ_XFER;
            end
          end
        end
        default: st <= SQ_IDLE;
      endcase
      if (finish && major_last) done <= 1'b1;
    end
  end

  assign bus_req = (st == SQ_XFER);
  assign bus_wr  = phase;

  dls_throttle u_thr (
    .clk      (clk),
    .rst      (rst),
    .load     (granted),
    .len      (gap),
    .hold_end (hold_end)
  );

  dls_major_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk    (clk),
    .rst    (rst),
    .ld_cur (wr_en && (wr_addr == A_CITER)),
    .ld_beg (wr_en && (wr_addr == A_BITER)),
    .wval   (wr_data[CNT_W-1:0]),
    .step   (finish),
    .cur    (citer),
    .last   (major_last)
  );

  dls_link #(.PTR_W(PTR_W)) u_link (
    .clk        (clk),
    .rst        (rst),
    .fire       (finish && major_last),
    .lk_en      (cfg.lk),
    .sg_en      (cfg.sg),
    .ch_in      (cfg.ch),
    .blk_in     (sg_blk),
    .link_valid (link_valid),
    .link_ch    (link_ch),
    .sg_req     (sg_req),
    .sg_ptr     (sg_ptr)
  );
endmodule

// File: rtl/dls_checker.sv
module dls_checker #(
  parameter int CNT_W = 15
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             err_in,
  input logic             bus_gnt,
  input logic             bus_req,
  input logic             bus_wr,
  input logic             active,
  input logic             done,
  input logic [CNT_W-1:0] citer,
  input logic             link_valid,
  input logic             sg_req
);
  assert_req_needs_active_R3: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> active);

  assert_req_held_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_gnt && !err_in) |=> (bus_req && $stable(bus_wr)));

  assert_active_excludes_done_R4: assert property (@(posedge clk) disable iff (rst)
    active |-> !done);

  assert_done_at_loop_end_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $fell(active));

  assert_error_abort_R9: assert property (@(posedge clk) disable iff (rst)
    (active && err_in) |=> (!active && !done));

  assert_count_idle_stable_R1: assert property (@(posedge clk) disable iff (rst)
    (!active && !wr_en) |=> $stable(citer));

  assert_link_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    link_valid |=> !link_valid);

  assert_reload_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    sg_req |=> !sg_req);
endmodule

bind dma_loop_seq dls_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .err_in     (err_in),
  .bus_gnt    (bus_gnt),
  .bus_req    (bus_req),
  .bus_wr     (bus_wr),
  .active     (active),
  .done       (done),
  .citer      (citer),
  .link_valid (link_valid),
  .sg_req     (sg_req)
);

// File: tb/dma_loop_seq_test.sv
module dma_loop_seq_test;
  localparam int CNT_W  = 15;
  localparam int BEAT_W = 4;
  localparam int PTR_W  = 32;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0;
  logic [2:0]       wr_addr = '0;
  logic [PTR_W-1:0] wr_data = '0;
  logic             hw_start = 1'b0;
  logic             err_in = 1'b0;
  logic             bus_gnt = 1'b1;
  logic             bus_req, bus_wr, active, done, link_valid, sg_req;
  logic [CNT_W-1:0] citer;
  logic [5:0]       link_ch;
  logic [PTR_W-1:0] sg_ptr;

  int checks = 0, errors = 0, cyc = 0;
  int n_active, n_acc, n_link, n_sg, link_at, sg_at, last_act_at, seq_bad;
  int seen_ch, seen_ptr;
  logic expect_wr;

  always #2 clk = ~clk;

  dma_loop_seq #(.CNT_W(CNT_W), .BEAT_W(BEAT_W), .PTR_W(PTR_W)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hw_start(hw_start), .err_in(err_in), .bus_gnt(bus_gnt),
    .bus_req(bus_req), .bus_wr(bus_wr), .active(active), .done(done),
    .citer(citer), .link_valid(link_valid), .link_ch(link_ch),
    .sg_req(sg_req), .sg_ptr(sg_ptr)
  );

  // Output monitor, sampled on the falling edge
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (active) begin n_active++; last_act_at = cyc; end
      if (bus_req && bus_gnt) begin
        n_acc++;
        if (bus_wr !== expect_wr) seq_bad++;
        expect_wr = ~expect_wr;
      end
      if (link_valid) begin n_link++; link_at = cyc; seen_ch = int'(link_ch); end
      if (sg_req) begin n_sg++; sg_at = cyc; seen_ptr = int'(sg_ptr); end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic clear_mon();
    n_active = 0; n_acc = 0; n_link = 0; n_sg = 0; seq_bad = 0;
    link_at = -1; sg_at = -1; last_act_at = -1; expect_wr = 1'b0;
  endtask

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [PTR_W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  function automatic logic [PTR_W-1:0] ctrl_word(input int bw, input int le, input int se,
                                                 input int ch, input int go);
    return PTR_W'((go << 10) | ((ch & 63) << 4) | (se << 3) | (le << 2) | (bw & 3));
  endfunction

  task automatic run_once();
    int guard;
    clear_mon();
    hw_start = 1'b1;
    step();
    hw_start = 1'b0;
    guard = 0;
    while (active && guard < 1000) begin step(); guard++; end
    repeat (4) step();
  endtask

  // Start then abort at once: clears done without touching the count
  task automatic abort_start();
    hw_start = 1'b1;
    step();
    hw_start = 1'b0;
    err_in = 1'b1;
    step();
    err_in = 1'b0;
    step();
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clear_mon();
    repeat (3) step();
    rst = 1'b0;
    step();
    // R11: reset state
    check_eq("R11", "active", int'(active), 0);
    check_eq("R11", "done", int'(done), 0);
    check_eq("R11", "bus_req", int'(bus_req), 0);
    check_eq("R11", "link_valid", int'(link_valid), 0);
    check_eq("R11", "sg_req", int'(sg_req), 0);
    check_eq("R11", "citer", int'(citer), 0);

    wreg(3'd4, 32'hABCD_E0FF);

    // Sweep throttle code x beats x major count
    for (int bw = 0; bw < 4; bw++) begin
      for (int b = 1; b <= 3; b++) begin
        for (int m = 1; m <= 3; m++) begin
          int s, le, se, ch;
          s  = (bw == 2) ? 4 : (bw == 3) ? 8 : 0;
          le = b % 2;
          se = (m >= 2) ? 1 : 0;
          ch = (bw * 9 + b * 3 + m) & 63;
          wreg(3'd0, PTR_W'(m));
          wreg(3'd1, PTR_W'(m));
          wreg(3'd3, PTR_W'(b));
          abort_start();
          check_eq("R9", "active after abort", int'(active), 0);
          check_eq("R9", "done after abort", int'(done), 0);
          check_eq("R9", "citer after abort", int'(citer), m);
          wreg(3'd2, ctrl_word(bw, le, se, ch, 0));
          for (int k = 1; k <= m; k++) begin
            run_once();
            check_eq("R1", "citer after minor loop", int'(citer), (k == m) ? m : m - k);
            check_eq("R4", "done after minor loop", int'(done), (k == m) ? 1 : 0);
            check_eq("R2", "active cycles", n_active, 2 * b * (1 + s));
            check_eq("R3", "granted accesses", n_acc, 2 * b);
            check_eq("R3", "read/write order faults", seq_bad, 0);
            check_eq("R5", "active after loop", int'(active), 0);
            if (k == m) begin
              check_eq("R6", "link pulses", n_link, le);
              if (le == 1) begin
                check_eq("R6", "link channel", seen_ch, ch);
                check_eq("R6", "link timing", link_at, last_act_at + 1);
              end
              check_eq("R7", "reload pulses", n_sg, se);
              if (se == 1) begin
                check_eq("R7", "reload timing", sg_at, last_act_at + 1 + le);
                check_eq("R7", "reload pointer", seen_ptr, int'(32'hABCD_E0E0));
              end
            end else begin
              check_eq("R6", "no link before end", n_link, 0);
              check_eq("R7", "no reload before end", n_sg, 0);
            end
          end
        end
      end
    end

    // R8: enables written while done is high are dropped
    check_eq("R8", "done before write", int'(done), 1);
    wreg(3'd0, 1); wreg(3'd1, 1); wreg(3'd3, 1);
    wreg(3'd4, 32'h1234_567F);
    wreg(3'd2, ctrl_word(0, 1, 1, 5, 0));
    run_once();
    check_eq("R8", "link pulses after forced write", n_link, 0);
    check_eq("R8", "reload pulses after forced write", n_sg, 0);
    abort_start();
    wreg(3'd2, ctrl_word(0, 1, 1, 5, 0));
    run_once();
    check_eq("R8", "link pulses after clean write", n_link, 1);
    check_eq("R6", "link channel 5", seen_ch, 5);
    check_eq("R7", "reload pulses after clean write", n_sg, 1);
    check_eq("R7", "aligned pointer", seen_ptr, int'(32'h1234_5660));
    check_eq("R7", "reload one after link", sg_at, link_at + 1);

    // R3: request held while grant is withheld
    wreg(3'd2, ctrl_word(0, 0, 0, 0, 0));
    wreg(3'd0, 2); wreg(3'd1, 2); wreg(3'd3, 1);
    clear_mon();
    bus_gnt = 1'b0;
    hw_start = 1'b1;
    step();
    hw_start = 1'b0;
    check_eq("R4", "done cleared at launch", int'(done), 0);
    check_eq("R5", "active at launch", int'(active), 1);
    for (int i = 0; i < 6; i++) begin
      check_eq("R3", "req held", int'(bus_req), 1);
      check_eq("R3", "read first", int'(bus_wr), 0);
      step();
    end
    bus_gnt = 1'b1;
    for (int i = 0; i < 20 && active; i++) step();
    check_eq("R3", "accesses after late grant", n_acc, 2);
    check_eq("R1", "citer after late grant", int'(citer), 1);

    // R10: software start runs once
    wreg(3'd0, 3); wreg(3'd1, 3); wreg(3'd3, 2);
    clear_mon();
    wreg(3'd2, ctrl_word(0, 0, 0, 0, 1));
    for (int i = 0; i < 10 && !active; i++) step();
    for (int i = 0; i < 50 && active; i++) step();
    repeat (20) step();
    check_eq("R10", "active cycles for one loop", n_active, 4);
    check_eq("R10", "citer after one loop", int'(citer), 2);
    check_eq("R10", "idle afterwards", int'(active), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule